// File: doc/BRIEF.md
# Read-Port Go-Pulse Responder and Handshake Checker

This block takes the place of a register-file read port sitting in front of a computation unit that hands out operand reads through a release/go handshake. It watches the unit's issue strobe, its busy flag and one read-release line per port. When a port's release rises after an issue, the block waits a stall count fixed per port and then answers with a go pulse on that port that lasts one clock. A port whose operand was marked as an immediate when the issue came in gets no go for that operation.

While it does this, the block checks the handshake timing every cycle. Release must not show up early. It must hold through the stall and the go cycle, and it must be gone the cycle after go. Busy must never overlap issue, must never rise on its own, and must fall within a bounded number of cycles after issue goes away. Each broken rule sets its own sticky flag. A done pulse marks the point where every port that was not skipped has delivered its go.

Top module: `rd_go_responder`

## Requirements
- R1: Take a port p with stall count S_p ≥ 1. Issue is sampled high in cycle t and release is high from cycle t+1 on. Then go_o[p] is high in cycle t+1+S_p. If release first shows in a later cycle u, go appears in cycle u+S_p.
- R2: After each issue, go_o[p] is high for exactly one cycle and is low in every other cycle.
- R3: If skip_i[p] is high in the issue cycle, port p produces no go for that operation and is not waited on for done.
- R4: Release on port p being high while that port is idle, or in the issue cycle, sets err_o[4p+0].
- R5: Release on port p being low in the cycle right after the issue sets err_o[4p+1]. The port keeps waiting and counts from the cycle release first shows.
- R6: Release on port p falling during the stall or in the go cycle sets err_o[4p+2]. A fall during the stall abandons the go.
- R7: Release on port p still being high in the cycle after its go sets err_o[4p+3].
- R8: An issue arriving while any port is mid-sequence (after the issue and up to its go cycle) sets err_o[4N+0], where N is the number of ports. It restarts that port with a freshly loaded stall count.
- R9: Issue and busy being high in the same cycle sets err_o[4N+1].
- R10: Busy rising in a cycle whose previous cycle had issue low sets err_o[4N+2].
- R11: Busy may stay high for up to BUSY_TMO consecutive cycles with issue low. Being high for the next such cycle sets err_o[4N+3].
- R12: Every error bit goes high in the cycle after the violation and stays high until rst_ni is asserted.
- R13: done_o pulses for one cycle in the cycle after the last go of the non-skipped ports. When all ports are skipped, it pulses in the cycle after the issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue strobe from the computation unit |
| busy_i | input | 1 | Busy flag from the computation unit |
| rel_i | input | NPORT | Per-port read-release request |
| skip_i | input | NPORT | Per-port immediate marker, sampled with issue |
| go_o | output | NPORT | Per-port one-cycle go pulse |
| done_o | output | 1 | All non-skipped ports have issued their go |
| err_o | output | 4*NPORT+4 | Sticky error flags, 4 per port then 4 global |

## Verification
The bench builds the block with two ports and a stall of 3 on port 0 and 1 on port 1, with a busy timeout of 50. The unequal stalls make done depend on the slower port. The stall of 1 exercises the path that skips the counting state and goes straight to go. The 50-cycle limit is hit at both 50 and 51 busy cycles, so the timeout boundary is tested on both sides. Random operations vary the skip mask and the busy length. The directed cases break one handshake rule each, and the bench compares the full error vector against the single expected bit.

// File: rtl/rgr_pkg.sv
package rgr_pkg;
  typedef enum logic [2:0] {
    PS_IDLE, PS_ARM, PS_STALL, PS_GO, PS_POST
  } port_st_e;

  localparam int unsigned PERR_W   = 4;
  localparam int unsigned PE_EARLY = 0;
  localparam int unsigned PE_NOREL = 1;
  localparam int unsigned PE_DROP  = 2;
  localparam int unsigned PE_LATE  = 3;

  localparam int unsigned GERR_W   = 4;
  localparam int unsigned BERR_W   = 3;
endpackage

// File: rtl/rgr_port_seq.sv
module rgr_port_seq
  import rgr_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned STALL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              skip_i,
  input  logic              rel_i,
  output logic              go_o,
  output logic              reissue_o,
  output logic [PERR_W-1:0] err_o
);
  localparam logic [CNT_W-1:0] STALL_M1 = CNT_W'(STALL - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  port_st_e          st_q, st_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [PERR_W-1:0] err_q, err_now;

  always_comb begin
    st_nx   = st_q;
    cnt_nx  = cnt_q;
    err_now = '0;
    if (issue_i) begin
      err_now[PE_EARLY] = rel_i;
      st_nx = skip_i ? PS_IDLE : PS_ARM;
    end else begin
      unique case (st_q)
        PS_IDLE: err_now[PE_EARLY] = rel_i;
        PS_ARM: begin
          if (!rel_i) begin
            err_now[PE_NOREL] = 1'b1;
          end else if (STALL == 1) begin
            st_nx = PS_GO;
          end else begin
            st_nx  = PS_STALL;
            cnt_nx = STALL_M1;
          end
        end
        PS_STALL: begin
          if (!rel_i) begin
            err_now[PE_DROP] = 1'b1;
            st_nx = PS_IDLE;
          end else if (cnt_q == CNT_ONE) begin
            st_nx = PS_GO;
          end else begin
            cnt_nx = cnt_q - CNT_ONE;
          end
        end
        PS_GO: begin
          err_now[PE_DROP] = !rel_i;
          st_nx = PS_POST;
        end
        PS_POST: begin
          err_now[PE_LATE] = rel_i;
          st_nx = PS_IDLE;
        end
        default: st_nx = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PS_IDLE;
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
      err_q <= err_q | err_now;
    end
  end

  assign go_o      = (st_q == PS_GO);
  assign reissue_o = issue_i && (st_q inside {PS_ARM, PS_STALL, PS_GO});
  assign err_o     = err_q;

  // R2
  go_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o);
  // R1
  go_after_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(rel_i));
endmodule

// File: rtl/rgr_busy_mon.sv
module rgr_busy_mon
  import rgr_pkg::*;
#(
  parameter int unsigned BUSY_TMO = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              busy_i,
  output logic [BERR_W-1:0] err_o
);
  localparam int unsigned    CW      = $clog2(BUSY_TMO + 1);
  localparam logic [CW-1:0]  TMO_LIM = CW'(BUSY_TMO);

  logic              busy_q, issue_q;
  logic [CW-1:0]     cnt_q;
  logic [BERR_W-1:0] err_q, err_now;
  logic              hold;

  assign hold       = busy_i && !issue_i;
  assign err_now[0] = issue_i && busy_i;
  assign err_now[1] = busy_i && !busy_q && !issue_q;
  assign err_now[2] = hold && (cnt_q >= TMO_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      issue_q <= 1'b0;
      cnt_q   <= '0;
      err_q   <= '0;
    end else begin
      busy_q  <= busy_i;
      issue_q <= issue_i;
      if (!hold)                cnt_q <= '0;
      else if (cnt_q < TMO_LIM) cnt_q <= cnt_q + CW'(1);
      err_q   <= err_q | err_now;
    end
  end

  assign err_o = err_q;

  // R11
  tmo_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[2]) |-> $past(busy_i));
endmodule

// File: rtl/rd_go_responder.sv
module rd_go_responder
  import rgr_pkg::*;
#(
  parameter int unsigned NPORT    = 2,
  parameter int unsigned CNT_W    = 4,
  parameter logic [NPORT*CNT_W-1:0] STALL_VEC = {4'd1, 4'd3},
  parameter int unsigned BUSY_TMO = 50,
  localparam int unsigned ERR_W   = PERR_W * NPORT + GERR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             busy_i,
  input  logic [NPORT-1:0] rel_i,
  input  logic [NPORT-1:0] skip_i,
  output logic [NPORT-1:0] go_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);
  logic [NPORT-1:0]  reiss, pend_q, pend_nx;
  logic              reiss_q, done_q;
  logic [BERR_W-1:0] berr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rgr_port_seq #(
      .CNT_W (CNT_W),
      .STALL (int'(STALL_VEC[p*CNT_W +: CNT_W]))
    ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (issue_i),
      .skip_i    (skip_i[p]),
      .rel_i     (rel_i[p]),
      .go_o      (go_o[p]),
      .reissue_o (reiss[p]),
      .err_o     (err_o[p*PERR_W +: PERR_W])
    );
  end

  rgr_busy_mon #(.BUSY_TMO(BUSY_TMO)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue_i),
    .busy_i  (busy_i),
    .err_o   (berr)
  );

  assign pend_nx = pend_q & ~go_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      done_q  <= 1'b0;
      reiss_q <= 1'b0;
    end else begin
      reiss_q <= reiss_q | (|reiss);
      if (issue_i) begin
        pend_q <= ~skip_i;
        done_q <= &skip_i;
      end else begin
        pend_q <= pend_nx;
        done_q <= (|pend_q) && (pend_nx == '0);
      end
    end
  end

  assign done_o = done_q;
  assign err_o[NPORT*PERR_W +: GERR_W] = {berr, reiss_q};

  // R12
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_o & $past(err_o)) == $past(err_o)));
  // R13
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(|go_o) || $past(issue_i)));
endmodule

// File: tb/rd_go_responder_tb_top.sv
module rd_go_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S0 = 3;
  localparam int S1 = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue, busy;
  logic [1:0]  rel, skip;
  logic [1:0]  go_o;
  logic        done_o;
  logic [11:0] err_o;
  int          n_chk = 0;
  int          n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_go_responder #(
    .NPORT(2), .CNT_W(4), .STALL_VEC({4'(S1), 4'(S0)}), .BUSY_TMO(50)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .busy_i(busy),
    .rel_i(rel), .skip_i(skip), .go_o(go_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int stall_of(input int p);
    return (p == 0) ? S0 : S1;
  endfunction

  function automatic logic [1:0] exp_go(input int k, input logic [1:0] sk);
    logic [1:0] v = '0;
    for (int p = 0; p < 2; p++) v[p] = !sk[p] && (k == 1 + stall_of(p));
    return v;
  endfunction

  function automatic logic [1:0] exp_rel(input int k, input logic [1:0] sk);
    logic [1:0] v = '0;
    for (int p = 0; p < 2; p++) v[p] = !sk[p] && (k >= 1) && (k <= 1 + stall_of(p));
    return v;
  endfunction

  function automatic logic exp_done(input int k, input logic [1:0] sk);
    int mx = 1;
    for (int p = 0; p < 2; p++) if (!sk[p] && 2 + stall_of(p) > mx) mx = 2 + stall_of(p);
    return k == mx;
  endfunction

  task automatic drv(input logic i, input logic b, input logic [1:0] r, input logic [1:0] s);
    issue = i; busy = b; rel = r; skip = s;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drv(0, 0, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset go", 32'(go_o), 0);
    chk("R13 reset done", 32'(done_o), 0);
    chk("R12 reset err", 32'(err_o), 0);
  endtask

  // well-behaved operation; busy high for cycles 1..b
  task automatic run_op(input logic [1:0] sk, input int b, input logic [11:0] xerr);
    int kk = ((b > 6) ? b : 6) + 2;
    for (int k = 0; k < kk; k++) begin
      @(negedge clk);
      chk("R1 R2 R3 go", 32'(go_o), 32'(exp_go(k, sk)));
      chk("R13 done", 32'(done_o), 32'(exp_done(k, sk)));
      drv(k == 0, (k >= 1) && (k <= b), exp_rel(k, sk), (k == 0) ? sk : 2'b00);
    end
    @(negedge clk);
    chk("R11 R12 err after op", 32'(err_o), 32'(xerr));
    drv(0, 0, 2'b00, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired (all requirements) act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [1:0] sk;
    int b;
    void'($urandom(32'd4242));
    do_reset();

    // directed: both ports, all skipped, timeout boundary
    run_op(2'b00, 3, 12'h000);
    run_op(2'b11, 2, 12'h000);
    run_op(2'b01, 50, 12'h000);

    // constrained random operations
    for (int i = 0; i < 40; i++) begin
      sk = 2'($urandom % 4);
      b  = 1 + int'($urandom % 50);
      run_op(sk, b, 12'h000);
      repeat ($urandom % 4) @(negedge clk);
    end

    // R4 early release while idle on port 1
    do_reset();
    drv(0, 0, 2'b10, 2'b00);
    @(negedge clk); drv(0, 0, 2'b00, 2'b00);
    repeat (2) @(negedge clk);
    chk("R4 early release", 32'(err_o), 32'h010);

    // R5 release late after issue, port 0 only
    do_reset();
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk("R5 go after late release", 32'(go_o), (k == 5) ? 1 : 0);
      drv(k == 0, 0, {1'b0, (k >= 2) && (k <= 5)}, (k == 0) ? 2'b10 : 2'b00);
    end
    chk("R5 norel flag", 32'(err_o), 32'h002);

    // R6 release dropped during stall
    do_reset();
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk("R6 no go after drop", 32'(go_o), 0);
      drv(k == 0, 0, {1'b0, (k >= 1) && (k <= 2)}, (k == 0) ? 2'b10 : 2'b00);
    end
    chk("R6 drop flag", 32'(err_o), 32'h004);

    // R7 release held past go on port 1
    do_reset();
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk("R7 go port1", 32'(go_o), (k == 2) ? 2 : 0);
      drv(k == 0, 0, {(k >= 1) && (k <= 3), 1'b0}, (k == 0) ? 2'b01 : 2'b00);
    end
    chk("R7 late flag", 32'(err_o), 32'h080);

    // R8 reissue mid-sequence restarts the stall count
    do_reset();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R8 go after reissue", 32'(go_o), (k == 6) ? 1 : 0);
      drv((k == 0) || (k == 2), 0, {1'b0, (k >= 1) && (k <= 6)},
          ((k == 0) || (k == 2)) ? 2'b10 : 2'b00);
    end
    chk("R8 reissue flag", 32'(err_o), 32'h101);

    // R9 issue while busy
    do_reset();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      drv((k == 0) || (k == 3), (k >= 1) && (k <= 3), 2'b00,
          ((k == 0) || (k == 3)) ? 2'b11 : 2'b00);
    end
    chk("R9 overlap flag", 32'(err_o), 32'h200);

    // R10 busy rising without issue
    do_reset();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      drv(0, (k >= 1) && (k <= 2), 2'b00, 2'b00);
    end
    chk("R10 self rise flag", 32'(err_o), 32'h400);

    // R11 one cycle over the limit, then R12 stickiness across a clean op
    do_reset();
    run_op(2'b11, 51, 12'h800);
    run_op(2'b00, 4, 12'h800);
    repeat (5) @(negedge clk);
    chk("R12 still sticky", 32'(err_o), 32'h800);
    do_reset();
    run_op(2'b10, 2, 12'h000);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule